// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects a set of interrupt request lines (32 by default) and merges them into one level interrupt line toward a processor. Software owns a table holding one 32-bit vector word per source. When the processor takes the interrupt, it reads the vector of the source that the controller has placed in service. It then runs the matching handler and writes the acknowledge register to let the next source through.

The request inputs are synchronized and stored as a raw status word. Each source has a mask bit. One register sets mask bits and another clears them, using write-one semantics. Of the pending unmasked sources, the controller places the lowest-numbered one in service and holds it until acknowledged. The interrupt line is asserted while a source is in service and the controller is enabled. Its active level is chosen by a control bit.

Access is through a simple register port with a byte address, a write strobe, write data and combinational read data.

Top module: `vic_top`

## Requirements
- R1: After reset the control register reads 0, the mask reads 0, every table entry reads 0, the vector register (byte offset 0x14) reads 0xFFFFFFFF, and `irq_out` is 1 (deasserted, active low).
- R2: The raw status register at offset 0x04 shows the request inputs two clock edges after they change, whatever the mask holds.
- R3: Writing the unmask register at offset 0x08 sets every mask bit whose data bit is 1 and leaves the others unchanged. The mask register at offset 0x10 reads the current mask, with bit i for source i.
- R4: Writing the mask-off register at offset 0x0C clears every mask bit whose data bit is 1 and leaves the others unchanged.
- R5: The table entry of source i is written and read at byte offset 0x80 + 4*i as a full 32-bit word.
- R6: Among the sources that are both raw-pending and unmasked, the lowest-numbered one is placed in service. Offset 0x14 then reads that source's table entry. With no source in service it reads 0xFFFFFFFF.
- R7: The source in service does not change until an acknowledge, even if its request drops or a lower-numbered source becomes pending.
- R8: Any write to offset 0x1C ends service. In the following cycles, the lowest pending unmasked source is placed in service, including the same source if its request is still high.
- R9: Control bit 0 enables the controller. While it is 0, `irq_out` is deasserted and no source enters service.
- R10: Control bit 1 sets the active level of `irq_out`: 1 for active high, 0 for active low. The line is active while enabled and a source is in service.
- R11: Offsets 0x08, 0x0C, 0x18, 0x1C and 0x20 to 0x7C read 0. Writes to 0x18 and 0x20 to 0x7C change no register and no table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | input | NUM_SRC | Asynchronous level interrupt requests |
| irq_out | output | 1 | Combined interrupt line at the programmed level |

## Verification
Two things can meet in one cycle: the acknowledge write that ends service, and a new lower-numbered request that arrived while another source was in service. The bench holds several requests high, raises a lower source during service, and checks that the vector does not move. It then acknowledges and checks that the newly raised source, not the older higher one, is taken next. A run of acknowledges then steps through the remaining sources in index order, checking that a source still held high is taken again at once.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_UNMASK  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASKOFF = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_VEC     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h1C;

    typedef struct packed {
        logic pol;   // 1: active-high output
        logic en;    // controller enable
    } ctrl_t;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_RAW,
        RG_UNMASK,
        RG_MASKOFF,
        RG_MASK,
        RG_VEC,
        RG_ACK,
        RG_TABLE
    } reg_sel_e;

    // Table lives in the upper half of the space, word aligned.
    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        if (a[ADDR_W-1] && a[1:0] == 2'b00) begin
            r = RG_TABLE;
        end else begin
            case (a)
                OFS_CTRL:    r = RG_CTRL;
                OFS_RAW:     r = RG_RAW;
                OFS_UNMASK:  r = RG_UNMASK;
                OFS_MASKOFF: r = RG_MASKOFF;
                OFS_MASK:    r = RG_MASK;
                OFS_VEC:     r = RG_VEC;
                OFS_ACK:     r = RG_ACK;
                default:     r = RG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vic_table.sv
module vic_table #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  bus_idx,
    output logic [DATA_W-1:0] bus_word,
    input  logic [IDX_W-1:0]  svc_idx,
    output logic [DATA_W-1:0] svc_word
);
    logic [DATA_W-1:0] mem [NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign bus_word = mem[bus_idx];
    assign svc_word = mem[svc_idx];
endmodule

// File: rtl/vic_select.sv
module vic_select #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic               allow,
    input  logic               ack,
    output logic               in_svc,
    output logic [IDX_W-1:0]   sel
);
    function automatic logic [IDX_W-1:0] lowest(input logic [NUM_SRC-1:0] p);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = NUM_SRC-1; i >= 0; i--) begin
            if (p[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            in_svc <= 1'b0;
            sel    <= '0;
        end else if (ack) begin
            in_svc <= 1'b0;
        end else if (!in_svc && allow && (|pend)) begin
            in_svc <= 1'b1;
            sel    <= lowest(pend);
        end
    end
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NUM_SRC     = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [vic_pkg::ADDR_W-1:0] bus_addr,
    input  logic                       bus_we,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_SRC-1:0]         irq_req,
    output logic                       irq_out
);
    import vic_pkg::*;

    reg_sel_e           rsel;
    ctrl_t              ctrl_q;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               in_svc;
    logic [IDX_W-1:0]   sel;
    logic [IDX_W-1:0]   tbl_idx;
    logic               tbl_hit;
    logic [DATA_W-1:0]  tbl_bus_word;
    logic [DATA_W-1:0]  tbl_svc_word;
    logic               active;

    assign rsel    = decode(bus_addr);
    assign tbl_idx = bus_addr[2 +: IDX_W];
    assign tbl_hit = (rsel == RG_TABLE) && (int'(bus_addr[ADDR_W-2:2]) < NUM_SRC);

    vic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_req),
        .q   (raw_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (bus_we) begin
            case (rsel)
                RG_CTRL:    ctrl_q <= '{pol: bus_wdata[1], en: bus_wdata[0]};
                RG_UNMASK:  mask_q <= mask_q | bus_wdata[NUM_SRC-1:0];
                RG_MASKOFF: mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
                default:    ;
            endcase
        end
    end

    vic_table #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we && tbl_hit),
        .wr_idx   (tbl_idx),
        .wr_data  (bus_wdata),
        .bus_idx  (tbl_idx),
        .bus_word (tbl_bus_word),
        .svc_idx  (sel),
        .svc_word (tbl_svc_word)
    );

    vic_select #(.NUM_SRC(NUM_SRC)) u_select (
        .clk    (clk),
        .rst    (rst),
        .pend   (raw_q & mask_q),
        .allow  (ctrl_q.en),
        .ack    (bus_we && rsel == RG_ACK),
        .in_svc (in_svc),
        .sel    (sel)
    );

    always_comb begin
        bus_rdata = '0;
        case (rsel)
            RG_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            RG_RAW:   bus_rdata = DATA_W'(raw_q);
            RG_MASK:  bus_rdata = DATA_W'(mask_q);
            RG_VEC:   bus_rdata = in_svc ? tbl_svc_word : {DATA_W{1'b1}};
            RG_TABLE: bus_rdata = tbl_hit ? tbl_bus_word : '0;
            default:  bus_rdata = '0;
        endcase
    end

    assign active  = ctrl_q.en && in_svc;
    assign irq_out = ctrl_q.pol ? active : !active;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               ctrl_en,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               in_svc,
    input logic [IDX_W-1:0]   sel
);
    logic [NUM_SRC-1:0] prev_pend;
    logic               is_ack;
    logic               is_unmask;
    logic               is_maskoff;

    assign is_ack     = bus_we && bus_addr == 8'h1C;
    assign is_unmask  = bus_we && bus_addr == 8'h08;
    assign is_maskoff = bus_we && bus_addr == 8'h0C;

    always_ff @(posedge clk) begin
        if (rst) prev_pend <= '0;
        else     prev_pend <= raw_q & mask_q;
    end

    AST_UNMASK_SETS: assert property (@(posedge clk) disable iff (rst)
        is_unmask |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0]))); // R3

    AST_MASKOFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        is_maskoff |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R4

    AST_PICK_PENDING: assert property (@(posedge clk) disable iff (rst)
        $rose(in_svc) |-> prev_pend[sel]); // R6

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
        $rose(in_svc) |-> ((prev_pend & ((NUM_SRC'(1) << sel) - NUM_SRC'(1))) == '0)); // R6

    AST_HOLD_SERVICE: assert property (@(posedge clk) disable iff (rst)
        (in_svc && !is_ack) |=> (in_svc && $stable(sel))); // R7

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (rst)
        is_ack |=> !in_svc); // R8

    AST_NO_PICK_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_en && !in_svc) |=> !in_svc); // R9
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_vic_checker (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .ctrl_en   (ctrl_q.en),
    .raw_q     (raw_q),
    .mask_q    (mask_q),
    .in_svc    (in_svc),
    .sel       (sel)
);

// File: tb/vic_top_test.sv
module vic_top_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] irq_req = '0;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;  // 250 MHz

    vic_top uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 | (32'(i) << 8) | (32'(i) ^ 32'hFF);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cyc(3);
        rst = 1'b0;

        // R1 reset state
        cyc(1);
        chk("R1 irq_out", 32'(irq_out), 32'd1);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h10, d); chk("R1 mask", d, 0);
        rd(8'h14, d); chk("R1 vector idle", d, 32'hFFFF_FFFF);
        rd(8'h80, d); chk("R1 table 0", d, 0);
        rd(8'hFC, d); chk("R1 table 31", d, 0);

        // R5 table sweep
        for (int i = 0; i < N; i++) wr(8'(8'h80 + 4*i), pat(i));
        for (int i = 0; i < N; i++) begin
            rd(8'(8'h80 + 4*i), d); chk($sformatf("R5 entry %0d", i), d, pat(i));
        end

        // R2 synchronizer depth, independent of mask (mask is zero)
        @(negedge clk); irq_req = 32'h8000_0001;
        bus_addr = 8'h04;
        @(negedge clk); chk("R2 raw after 1 edge", bus_rdata, 0);
        @(negedge clk); chk("R2 raw after 2 edges", bus_rdata, 32'h8000_0001);
        irq_req = '0; cyc(3);

        // R3 / R4 mask set and clear
        wr(8'h08, 32'h0000_00F0);
        wr(8'h08, 32'h0000_0003);
        rd(8'h10, d); chk("R3 unmask merge", d, 32'h0000_00F3);
        wr(8'h0C, 32'h0000_0021);
        rd(8'h10, d); chk("R4 maskoff", d, 32'h0000_00D2);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R4 maskoff all", d, 0);

        // Masked request: no service (R6)
        wr(8'h00, 32'h1);
        irq_req = 32'h0000_0400; cyc(5);
        rd(8'h14, d); chk("R6 masked source ignored", d, 32'hFFFF_FFFF);
        chk("R6 masked no irq", 32'(irq_out), 32'd1);
        irq_req = '0; cyc(3);

        // Per-source sweep (R6, R7, R8, R10 active low)
        for (int i = 0; i < N; i++) begin
            wr(8'h08, 32'(1) << i);
            irq_req = N'(1) << i; cyc(5);
            chk($sformatf("R10 active low src %0d", i), 32'(irq_out), 32'd0);
            rd(8'h14, d); chk($sformatf("R6 vector src %0d", i), d, pat(i));
            irq_req = '0; cyc(4);
            rd(8'h14, d); chk($sformatf("R7 held src %0d", i), d, pat(i));
            wr(8'h1C, 32'h0);
            chk($sformatf("R8 released src %0d", i), 32'(irq_out), 32'd1);
            wr(8'h0C, 32'(1) << i);
        end

        // Priority ordering with a late lower request (R6, R7, R8)
        wr(8'h08, 32'hFFFF_FFFF);
        irq_req = (N'(1) << 3) | (N'(1) << 7) | (N'(1) << 20); cyc(5);
        rd(8'h14, d); chk("R6 lowest of 3,7,20", d, pat(3));
        irq_req[1] = 1'b1; cyc(5);
        rd(8'h14, d); chk("R7 late lower waits", d, pat(3));
        wr(8'h1C, 32'h1234); cyc(2);
        rd(8'h14, d); chk("R8 late lower taken", d, pat(1));
        irq_req[1] = 1'b0; cyc(3);
        wr(8'h1C, 0); cyc(2);
        rd(8'h14, d); chk("R8 still-high source retaken", d, pat(3));
        irq_req[3] = 1'b0; cyc(3);
        wr(8'h1C, 0); cyc(2);
        rd(8'h14, d); chk("R8 next 7", d, pat(7));
        irq_req[7] = 1'b0; cyc(3);
        wr(8'h1C, 0); cyc(2);
        rd(8'h14, d); chk("R8 next 20", d, pat(20));
        irq_req = '0; cyc(3);
        wr(8'h1C, 0); cyc(2);
        rd(8'h14, d); chk("R8 none left", d, 32'hFFFF_FFFF);
        chk("R8 line idle", 32'(irq_out), 32'd1);

        // R10 active high
        wr(8'h00, 32'h3);
        chk("R10 idle high-pol", 32'(irq_out), 32'd0);
        irq_req[5] = 1'b1; cyc(5);
        chk("R10 active high", 32'(irq_out), 32'd1);
        irq_req = '0; cyc(3);
        wr(8'h1C, 0);
        chk("R10 released high-pol", 32'(irq_out), 32'd0);

        // R9 disabled controller
        wr(8'h00, 32'h2);
        irq_req[6] = 1'b1; cyc(6);
        chk("R9 disabled no irq", 32'(irq_out), 32'd0);
        rd(8'h14, d); chk("R9 disabled no service", d, 32'hFFFF_FFFF);
        wr(8'h00, 32'h3); cyc(2);
        chk("R9 enabled irq", 32'(irq_out), 32'd1);
        rd(8'h14, d); chk("R9 enabled vector", d, pat(6));
        wr(8'h00, 32'h2);
        chk("R9 disable drops line", 32'(irq_out), 32'd0);
        irq_req = '0; cyc(3);
        wr(8'h1C, 0);

        // R11 unmapped and write-only offsets
        wr(8'h18, 32'hDEAD_BEEF);
        wr(8'h7C, 32'hCAFE_F00D);
        wr(8'h20, 32'h0000_0001);
        rd(8'h18, d); chk("R11 0x18 reads 0", d, 0);
        rd(8'h7C, d); chk("R11 0x7C reads 0", d, 0);
        rd(8'h08, d); chk("R11 0x08 reads 0", d, 0);
        rd(8'h1C, d); chk("R11 0x1C reads 0", d, 0);
        rd(8'hFC, d); chk("R11 table 31 intact", d, pat(31));
        rd(8'h80, d); chk("R11 table 0 intact", d, pat(0));
        rd(8'h00, d); chk("R11 ctrl intact", d, 32'h2);
        rd(8'h10, d); chk("R11 mask intact", d, 32'hFFFF_FFFF);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule